// File: doc/BRIEF.md
# SPI Master Controller with Byte FIFOs

This block is a bus-attached SPI master. Software talks to it through a 32-bit word register bus with a one-cycle read latency. Bytes written to the transmit data register are queued in a transmit FIFO. A shift engine sends each queued byte as an 8-bit frame on `mosi` and captures one byte from `miso` into a receive FIFO. Frame polarity, phase and bit order are set in the control register. An internal loopback path feeds the serial output back into the receiver. A hold bit in the control register keeps the engine idle, so software can queue a whole burst first and then release it as back-to-back frames.

The device-select pins are active low, with one pin per device, and are driven from a select register. In manual mode the register value appears directly on the pins. In automatic mode the pins follow the register only while a frame is in flight and otherwise stay all ones. A software reset register restores the whole block when it receives a key value. Two self-clearing control bits empty either FIFO. The serial clock comes from a fixed divider of the system clock.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, the control register (0x60) reads 0x180 (hold bit 8 and manual-select bit 7 set), status (0x64) reads 0x25, the select register (0x70) and `ss_n` read all ones, and `sck` is 0.
- R2: The interrupt stub registers at 0x1C, 0x20 and 0x28 always read 0, and writes to them have no effect.
- R3: Writes to the TX data register (0x68) fill a FIFO of FIFO_DEPTH entries. Status bit 3 (TX full) sets on exactly the FIFO_DEPTH-th write, and any further write is dropped.
- R4: The occupancy registers (TX 0x74, RX 0x78) read the entry count minus one, or 0 when the FIFO is empty. Status bit 2 (TX idle) is 1 only when the TX FIFO is empty and no frame is in progress. Status bit 0 is RX empty, bit 1 is RX full, and bit 5 reads 1.
- R5: While control bit 8 (hold) is 1, `sck` does not toggle and no byte is received, even with data queued. Clearing the bit sends every queued byte in order.
- R6: Each frame is 8 bits and carries bits [7:0] of the written word. Each frame pushes exactly one byte into the RX FIFO.
- R7: `sck` idles at control bit 3 (CPOL). With control bit 4 (CPHA) at 0, data is sampled on the first clock edge of each bit. With CPHA at 1, it is sampled on the second edge.
- R8: With control bit 9 at 0, bit 7 is sent and received first. With bit 9 at 1, bit 0 goes first.
- R9: With control bit 0 (loopback) set, each received byte equals the byte sent, whatever the level on `miso`.
- R10: Writing 1 to control bit 5 empties the TX FIFO, and writing 1 to bit 6 empties the RX FIFO. Both bits read back as 0.
- R11: Writing 0x0A to 0x40 restores every register and both FIFOs to their reset values. Any other value written there changes nothing.
- R12: With control bit 7 at 1, `ss_n` equals the select register. With bit 7 at 0, `ss_n` equals the select register during a frame and is all ones otherwise.
- R13: Reading RX data (0x6C) when the RX FIFO is empty returns 0 and removes nothing. Frames run only when control bit 1 (enable) and bit 2 (master) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low device selects |

## Verification
A register read returns data one clock after the strobe, so the bench drives strobes on the falling edge and takes `bus_rdata` on the next falling edge. A control, select or reset write takes effect at the first rising edge and reaches `sck` and `ss_n` one cycle later, so the bench waits two cycles before checking those pins. A frame takes 16 half-periods of CLK_DIV cycles, followed by one more cycle to push the received byte. The bench does not count out that time. It polls the TX-idle status bit, which already accounts for that push, before it reads the RX data. The serial-side checks come from a slave model in the bench. The model samples `mosi` and moves `miso` on each edge that the selected mode names as the sampling edge.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int FRAME_W = 8;

  localparam logic [7:0] OFF_GIE    = 8'h1C;
  localparam logic [7:0] OFF_ISR    = 8'h20;
  localparam logic [7:0] OFF_IER    = 8'h28;
  localparam logic [7:0] OFF_SRST   = 8'h40;
  localparam logic [7:0] OFF_CTL    = 8'h60;
  localparam logic [7:0] OFF_STAT   = 8'h64;
  localparam logic [7:0] OFF_TXD    = 8'h68;
  localparam logic [7:0] OFF_RXD    = 8'h6C;
  localparam logic [7:0] OFF_SEL    = 8'h70;
  localparam logic [7:0] OFF_TXOCC  = 8'h74;
  localparam logic [7:0] OFF_RXOCC  = 8'h78;

  localparam logic [31:0] SRST_KEY = 32'h0000_000A;

  localparam int CB_LOOP   = 0;
  localparam int CB_EN     = 1;
  localparam int CB_MASTER = 2;
  localparam int CB_CPOL   = 3;
  localparam int CB_CPHA   = 4;
  localparam int CB_TXRST  = 5;
  localparam int CB_RXRST  = 6;
  localparam int CB_MANUAL = 7;
  localparam int CB_HOLD   = 8;
  localparam int CB_LSB    = 9;

  typedef struct packed {
    logic lsb;
    logic hold;
    logic manual;
    logic cpha;
    logic cpol;
    logic master;
    logic en;
    logic loop;
  } ctl_t;

  function automatic logic [FRAME_W-1:0] bit_rev(input logic [FRAME_W-1:0] v);
    logic [FRAME_W-1:0] r;
    for (int i = 0; i < FRAME_W; i++) r[i] = v[FRAME_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic [AW:0]  count,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rdata   = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
  a_r3_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> count == $past(count));
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int CLK_DIV = 4,
  localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
  localparam int EDGES  = 2 * FRAME_W,
  localparam int EW     = $clog2(EDGES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpol,
  input  logic               cpha,
  input  logic               lsb,
  input  logic               go,
  input  logic [FRAME_W-1:0] tx_byte,
  input  logic               ser_in,
  output logic               sck,
  output logic               ser_out,
  output logic               busy,
  output logic               rx_valid,
  output logic [FRAME_W-1:0] rx_byte
);
  logic [DIV_W-1:0]   div_cnt;
  logic [EW-1:0]      edge_cnt;
  logic [FRAME_W-1:0] txsh, rxsh, rx_next, rx_final;
  logic               tick, sample_edge, last_edge;

  assign ser_out     = txsh[FRAME_W-1];
  assign tick        = busy && (div_cnt == DIV_W'(CLK_DIV-1));
  // even edge index = leading edge; sample on leading edge when cpha=0
  assign sample_edge = (~edge_cnt[0]) ^ cpha;
  assign last_edge   = (edge_cnt == EW'(EDGES-1));

  always_comb begin
    rx_next  = {rxsh[FRAME_W-2:0], ser_in};
    rx_final = cpha ? rx_next : rxsh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sck      <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      txsh     <= '0;
      rxsh     <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!busy) begin
        sck <= cpol;
        if (go) begin
          busy     <= 1'b1;
          txsh     <= lsb ? bit_rev(tx_byte) : tx_byte;
          div_cnt  <= '0;
          edge_cnt <= '0;
        end
      end else if (tick) begin
        div_cnt  <= '0;
        sck      <= ~sck;
        edge_cnt <= edge_cnt + 1'b1;
        if (sample_edge) rxsh <= rx_next;
        else if (edge_cnt != '0) txsh <= {txsh[FRAME_W-2:0], 1'b0};
        if (last_edge) begin
          busy     <= 1'b0;
          rx_valid <= 1'b1;
          rx_byte  <= lsb ? bit_rev(rx_final) : rx_final;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  a_r7_sck_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cpol)) |-> sck == cpol);
  a_r6_one_byte_per_frame: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (!busy && $past(busy)));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int NSS        = 4,
  parameter int CLK_DIV    = 4,
  parameter int ADDR_W     = 8,
  localparam int AW        = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NSS-1:0]    ss_n
);
  logic srst_q, core_rst;
  always_ff @(posedge clk) begin
    if (rst) srst_q <= 1'b0;
    else     srst_q <= bus_wr && (bus_addr == ADDR_W'(OFF_SRST)) && (bus_wdata == SRST_KEY);
  end
  assign core_rst = rst | srst_q;

  logic wr_ctl, wr_txd, wr_sel, rd_rxd;
  assign wr_ctl = bus_wr && (bus_addr == ADDR_W'(OFF_CTL));
  assign wr_txd = bus_wr && (bus_addr == ADDR_W'(OFF_TXD));
  assign wr_sel = bus_wr && (bus_addr == ADDR_W'(OFF_SEL));
  assign rd_rxd = bus_rd && (bus_addr == ADDR_W'(OFF_RXD));

  ctl_t           ctl;
  logic [NSS-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (core_rst) begin
      ctl        <= '0;
      ctl.hold   <= 1'b1;
      ctl.manual <= 1'b1;
      sel_q      <= '1;
    end else begin
      if (wr_ctl) begin
        ctl.loop   <= bus_wdata[CB_LOOP];
        ctl.en     <= bus_wdata[CB_EN];
        ctl.master <= bus_wdata[CB_MASTER];
        ctl.cpol   <= bus_wdata[CB_CPOL];
        ctl.cpha   <= bus_wdata[CB_CPHA];
        ctl.manual <= bus_wdata[CB_MANUAL];
        ctl.hold   <= bus_wdata[CB_HOLD];
        ctl.lsb    <= bus_wdata[CB_LSB];
      end
      if (wr_sel) sel_q <= bus_wdata[NSS-1:0];
    end
  end

  logic [FRAME_W-1:0] tx_head, rx_head, rx_byte;
  logic [AW:0]        tx_cnt, rx_cnt;
  logic               tx_empty, tx_full, rx_empty, rx_full;
  logic               busy, rx_valid, start, ser_in, ser_out, tx_idle;

  assign start   = !busy && ctl.en && ctl.master && !ctl.hold && !tx_empty;
  assign tx_idle = tx_empty && !busy && !rx_valid;
  assign ser_in  = ctl.loop ? ser_out : miso;
  assign mosi    = ser_out;

  spim_fifo #(.DEPTH(FIFO_DEPTH), .W(FRAME_W)) tx_fifo_i (
    .clk(clk), .rst(core_rst), .flush(wr_ctl && bus_wdata[CB_TXRST]),
    .push(wr_txd), .wdata(bus_wdata[FRAME_W-1:0]), .pop(start),
    .rdata(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full));

  spim_fifo #(.DEPTH(FIFO_DEPTH), .W(FRAME_W)) rx_fifo_i (
    .clk(clk), .rst(core_rst), .flush(wr_ctl && bus_wdata[CB_RXRST]),
    .push(rx_valid), .wdata(rx_byte), .pop(rd_rxd && !rx_empty),
    .rdata(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full));

  spim_shift #(.CLK_DIV(CLK_DIV)) shift_i (
    .clk(clk), .rst(core_rst), .cpol(ctl.cpol), .cpha(ctl.cpha), .lsb(ctl.lsb),
    .go(start), .tx_byte(tx_head), .ser_in(ser_in), .sck(sck), .ser_out(ser_out),
    .busy(busy), .rx_valid(rx_valid), .rx_byte(rx_byte));

  always_ff @(posedge clk) begin
    if (core_rst)        ss_n <= '1;
    else if (ctl.manual) ss_n <= sel_q;
    else                 ss_n <= busy ? sel_q : '1;
  end

  function automatic logic [31:0] occ(input logic [AW:0] c);
    return (c == '0) ? 32'd0 : 32'(c - 1'b1);
  endfunction

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFF_CTL): begin
        rd_mux[CB_LOOP]   = ctl.loop;
        rd_mux[CB_EN]     = ctl.en;
        rd_mux[CB_MASTER] = ctl.master;
        rd_mux[CB_CPOL]   = ctl.cpol;
        rd_mux[CB_CPHA]   = ctl.cpha;
        rd_mux[CB_MANUAL] = ctl.manual;
        rd_mux[CB_HOLD]   = ctl.hold;
        rd_mux[CB_LSB]    = ctl.lsb;
      end
      ADDR_W'(OFF_STAT):  rd_mux[5:0] = {1'b1, 1'b0, tx_full, tx_idle, rx_full, rx_empty};
      ADDR_W'(OFF_RXD):   rd_mux[FRAME_W-1:0] = rx_empty ? '0 : rx_head;
      ADDR_W'(OFF_SEL):   rd_mux[NSS-1:0] = sel_q;
      ADDR_W'(OFF_TXOCC): rd_mux = occ(tx_cnt);
      ADDR_W'(OFF_RXOCC): rd_mux = occ(rx_cnt);
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (core_rst)    bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  a_r5_hold_blocks_start: assert property (@(posedge clk) disable iff (core_rst)
    (ctl.hold && !busy) |=> !busy);
  a_r13_needs_enable: assert property (@(posedge clk) disable iff (core_rst)
    (!(ctl.en && ctl.master) && !busy) |=> !busy);
  a_r12_auto_select_idle: assert property (@(posedge clk) disable iff (core_rst)
    $past(!ctl.manual && !busy) |-> (ss_n == '1));
  a_r12_one_device: assert property (@(posedge clk) disable iff (core_rst)
    (ctl.manual && $countones(~sel_q) <= 1) |=> $countones(~ss_n) <= 1);
endmodule

// File: tb/spim_ctrl_tb.sv
module spim_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int NSS = 4;

  logic clk = 0, rst = 1;
  logic [7:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sck, mosi, miso;
  logic [NSS-1:0] ss_n;

  int n_checks = 0, n_fail = 0;

  logic tb_cpol = 0, tb_cpha = 0, tb_lsb = 0, tb_miso = 0;
  logic [7:0] tb_pat = 0, mos_byte = 0;
  logic [NSS-1:0] ss_rec = '1;
  int bitcnt = 0, edges = 0;

  assign miso = tb_miso;

  always #(CLK_PERIOD/2) clk = ~clk;

  spim_ctrl #(.FIFO_DEPTH(DEPTH), .NSS(NSS), .CLK_DIV(2)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_n(ss_n));

  always @(posedge sck or negedge sck) begin
    edges++;
    if (sck == (tb_cpol ^ !tb_cpha) && bitcnt < 8) begin
      if (tb_lsb) mos_byte[bitcnt] = mosi; else mos_byte[7-bitcnt] = mosi;
      ss_rec = ss_n;
      bitcnt++;
      if (bitcnt < 8) tb_miso = tb_lsb ? tb_pat[bitcnt] : tb_pat[7-bitcnt];
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(8'h64, s);
      if (s[2]) return;
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int e0;
    repeat (3) @(negedge clk);
    rst = 0;
    cycles(2);

    // R1 reset state
    rd(8'h60, v); chk("R1", "ctl reset", v, 32'h180);
    rd(8'h64, v); chk("R1", "status reset", v, 32'h25);
    rd(8'h70, v); chk("R1", "select reset", v, 32'hF);
    chk("R1", "ss_n pins", ss_n, 4'hF);
    chk("R1", "sck reset", sck, 0);

    // R2 interrupt stubs
    wr(8'h1C, 32'hFFFF_FFFF); wr(8'h20, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h1C, v); chk("R2", "gie", v, 0);
    rd(8'h20, v); chk("R2", "isr", v, 0);
    rd(8'h28, v); chk("R2", "ier", v, 0);

    // R3/R4 fill until full while held
    for (int k = 1; k <= DEPTH; k++) begin
      wr(8'h68, k);
      rd(8'h64, v); chk("R3", "status during fill", v, 32'h21 | ((k == DEPTH) ? 32'h8 : 0));
      rd(8'h74, v); chk("R4", "tx occupancy", v, k - 1);
    end
    wr(8'h68, 32'h77);
    rd(8'h74, v); chk("R3", "occupancy after dropped write", v, DEPTH - 1);

    // R10 tx flush
    wr(8'h60, 32'h180 | 32'h20);
    rd(8'h60, v); chk("R10", "flush bit reads 0", v, 32'h180);
    rd(8'h74, v); chk("R10", "tx occ after flush", v, 0);
    rd(8'h64, v); chk("R10", "status after flush", v, 32'h25);

    // R13 empty RX read
    rd(8'h6C, v); chk("R13", "rx read when empty", v, 0);
    rd(8'h78, v); chk("R13", "rx occ unchanged", v, 0);

    // R13 no shifting without enable
    wr(8'h60, 32'h84);
    wr(8'h68, 32'h5A);
    cycles(100);
    rd(8'h64, v); chk("R13", "no frame without enable", v, 32'h21);
    wr(8'h60, 32'h84 | 32'h20);

    // R5 hold, R9 loopback, R6 low byte
    wr(8'h60, 32'h187);
    e0 = edges;
    wr(8'h68, 32'h11); wr(8'h68, 32'h22); wr(8'h68, 32'hABCD33);
    cycles(150);
    chk("R5", "no sck edges while held", edges - e0, 0);
    rd(8'h64, v); chk("R5", "nothing received while held", v, 32'h21);
    wr(8'h60, 32'h087);
    wait_idle();
    rd(8'h78, v); chk("R5", "rx occ after release", v, 2);
    rd(8'h6C, v); chk("R9", "loopback byte 0", v, 32'h11);
    rd(8'h6C, v); chk("R9", "loopback byte 1", v, 32'h22);
    rd(8'h6C, v); chk("R6", "only low 8 bits sent", v, 32'h33);
    rd(8'h64, v); chk("R4", "status drained", v, 32'h25);

    // R10 rx flush
    wr(8'h68, 32'h44); wait_idle();
    rd(8'h64, v); chk("R10", "rx holds byte", v[0], 0);
    wr(8'h60, 32'h087 | 32'h40);
    rd(8'h64, v); chk("R10", "rx flushed", v, 32'h25);

    // R7/R8 mode sweep with external slave model
    wr(8'h70, 32'hE);
    for (int m = 0; m < 8; m++) begin
      for (int b = 0; b < 4; b++) begin
        logic [7:0] byt;
        logic [31:0] c;
        byt = (b == 0) ? 8'hA5 : (b == 1) ? 8'h3C : (b == 2) ? 8'h01 : 8'h80;
        c = 32'h86 | (m[0] ? 32'h8 : 0) | (m[1] ? 32'h10 : 0) | (m[2] ? 32'h200 : 0);
        wr(8'h60, c);
        cycles(2);
        chk("R7", "sck idle level", sck, m[0]);
        tb_cpol = m[0]; tb_cpha = m[1]; tb_lsb = m[2];
        tb_pat = byt ^ 8'h5A; bitcnt = 0; mos_byte = 0;
        tb_miso = m[2] ? tb_pat[0] : tb_pat[7];
        wr(8'h68, byt);
        wait_idle();
        rd(8'h6C, v);
        chk(m[2] ? "R8" : "R7", "received byte", v, tb_pat);
        chk(m[2] ? "R8" : "R7", "sent bit order", mos_byte, byt);
        chk("R6", "eight sample edges", bitcnt, 8);
      end
    end
    tb_cpol = 0; tb_cpha = 0; tb_lsb = 0;

    // R12 automatic and manual select
    wr(8'h60, 32'h06);
    wr(8'h70, 32'hD);
    cycles(2);
    chk("R12", "auto idle pins", ss_n, 4'hF);
    bitcnt = 0; ss_rec = '1;
    wr(8'h68, 32'h96);
    wait_idle();
    chk("R12", "auto pins during frame", ss_rec, 4'hD);
    cycles(2);
    chk("R12", "auto pins after frame", ss_n, 4'hF);
    rd(8'h6C, v);
    wr(8'h60, 32'h86);
    cycles(2);
    chk("R12", "manual pins follow reg", ss_n, 4'hD);

    // R11 software reset
    wr(8'h40, 32'h05);
    cycles(2);
    rd(8'h60, v); chk("R11", "non-key ignored", v, 32'h86);
    wr(8'h60, 32'h186);
    wr(8'h68, 32'h12);
    wr(8'h40, 32'h0A);
    cycles(2);
    rd(8'h60, v); chk("R11", "ctl after key", v, 32'h180);
    rd(8'h70, v); chk("R11", "select after key", v, 32'hF);
    rd(8'h64, v); chk("R11", "status after key", v, 32'h25);
    chk("R11", "pins after key", ss_n, 4'hF);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule